// File: doc/BRIEF.md
# Function Unit Dependency Matrix

This block tracks read-after-write waits between the function units of an issue stage. It holds one row and one column per unit. When an instruction is issued to a unit, that unit's row records which other units must first deliver results it will read. When a unit completes, its column is erased from every row, and the units that were waiting on it may go ahead. A unit's ready output rises once the unit holds an instruction and every unit it waits on has completed. Register contents and the arithmetic itself are handled elsewhere.

Wide units (32-bit, ids 0 to 3) and narrow units (8-bit, ids 4 to 7) share the one matrix. A wide unit can therefore wait on a narrow one, and the reverse also holds. A double-width operation takes two adjacent units of the same group (ids 2k and 2k+1). It is issued and retired as a pair, and its pair-ready output needs both halves to be ready.

Top module: `dep_matrix`

## Requirements
- R1: After reset no unit is busy, and unitReady and pairReady are all zero.
- R2: An issue whose producer mask names no busy unit makes unitReady[unit] high in the cycle after the issue edge.
- R3: An issue whose mask names a busy unit holds unitReady[unit] low. It rises in the cycle after that producer's completion edge.
- R4: With several producers, unitReady stays low until the last of them has completed.
- R5: Wide units (ids 0-3) and narrow units (ids 4-7) may depend on each other in either direction.
- R6: A mask bit naming the issuing unit itself is ignored.
- R7: A mask bit naming a unit that is not busy is ignored.
- R8: A completion clears that unit's busy state, so its unitReady is low in the following cycle.
- R9: If a producer completes in the same cycle as an issue that names it, the dependency is not recorded.
- R10: With issuePair set, units 2k and 2k+1 (k = issueUnit>>1) both load the mask and do not depend on each other. pairReady[k] is high only when both halves are ready.
- R11: With donePair set, both units of pair k = doneUnit>>1 complete in that cycle.
- R12: An issue and a completion to the same unit in one cycle leave the unit busy with the newly issued row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue strobe |
| issueUnit | input | 3 | Unit that receives the instruction |
| issuePair | input | 1 | Issue to both units of the pair holding issueUnit |
| issueMask | input | 8 | Units whose results the instruction reads |
| doneValid | input | 1 | Completion strobe |
| doneUnit | input | 3 | Unit that completed |
| donePair | input | 1 | Completion covers both units of the pair |
| unitReady | output | 8 | Unit is busy and has no open dependency |
| pairReady | output | 4 | Both units of pair k are ready |

## Verification
Issue and completion can fall in the same cycle in two ways. In the first, the completing unit is a producer named by the issue. In the second, it is the unit being issued to. Directed scenarios drive both strobes on one edge. The R9 case is judged by unitReady being high one cycle later. The R12 case is judged by the unit staying busy and waiting on its new producer until that producer completes.

// File: rtl/dep_matrix_pkg.sv
package dep_matrix_pkg;
  localparam int NUM_WIDE   = 4;
  localparam int NUM_NARROW = 4;
  localparam int NUM_UNITS  = NUM_WIDE + NUM_NARROW;
  localparam int NUM_PAIRS  = NUM_UNITS / 2;
  localparam int ID_W       = $clog2(NUM_UNITS);

  typedef logic [NUM_UNITS-1:0] unitVec_t;

  typedef struct packed {
    unitVec_t loadRow;
    unitVec_t clearUnit;
    unitVec_t rowMask;
  } strobe_t;
endpackage

// File: rtl/dep_ctrl.sv
module dep_ctrl
  import dep_matrix_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic [ID_W-1:0] issueUnit,
  input  logic            issuePair,
  input  unitVec_t        issueMask,
  input  logic            doneValid,
  input  logic [ID_W-1:0] doneUnit,
  input  logic            donePair,
  input  unitVec_t        busy,
  output strobe_t         strobe
);
  unitVec_t issueSel;
  unitVec_t doneSel;

  // Decode a unit id, widened to its pair when requested
  always_comb begin
    issueSel = '0;
    doneSel  = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (issueValid) begin
        if (issuePair) issueSel[i] = (ID_W'(i) >> 1) == (issueUnit >> 1);
        else           issueSel[i] = ID_W'(i) == issueUnit;
      end
      if (doneValid) begin
        if (donePair) doneSel[i] = (ID_W'(i) >> 1) == (doneUnit >> 1);
        else          doneSel[i] = ID_W'(i) == doneUnit;
      end
    end
  end

  // Keep only producers that are still pending and not retiring now
  always_comb begin
    strobe.loadRow   = issueSel;
    strobe.clearUnit = doneSel;
    strobe.rowMask   = issueMask & busy & ~doneSel & ~issueSel;
  end

  // R10
  issue_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> ($countones(strobe.loadRow) == (issuePair ? 2 : 1)));

  // R11
  done_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> ($countones(strobe.clearUnit) == (donePair ? 2 : 1)));

  // R7
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rowMask & ~busy) == '0);
endmodule

// File: rtl/dep_datapath.sv
module dep_datapath
  import dep_matrix_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  output unitVec_t             busy,
  output unitVec_t             unitReady,
  output logic [NUM_PAIRS-1:0] pairReady
);
  unitVec_t depRow [NUM_UNITS];

  for (genvar r = 0; r < NUM_UNITS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) begin
        depRow[r] <= '0;
        busy[r]   <= 1'b0;
      end else if (strobe.loadRow[r]) begin
        depRow[r] <= strobe.rowMask;
        busy[r]   <= 1'b1;
      end else if (strobe.clearUnit[r]) begin
        depRow[r] <= '0;
        busy[r]   <= 1'b0;
      end else begin
        depRow[r] <= depRow[r] & ~strobe.clearUnit;
      end
    end

    assign unitReady[r] = busy[r] && (depRow[r] == '0);

    // R6
    no_self_dep_chk: assert property (@(posedge clk) disable iff (!rstN)
      !depRow[r][r]);

    // R8
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clearUnit[r] && !strobe.loadRow[r]) |=> !busy[r]);

    // R2
    free_issue_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadRow[r] && strobe.rowMask == '0) |=> unitReady[r]);

    // R12
    reissue_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadRow[r] && strobe.clearUnit[r]) |=> busy[r]);
  end

  for (genvar c = 0; c < NUM_UNITS; c++) begin : g_col
    unitVec_t colBits;
    always_comb begin
      for (int r = 0; r < NUM_UNITS; r++) colBits[r] = depRow[r][c];
    end

    // R3
    column_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clearUnit[c] |=> (colBits == '0));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pairReady[p] = unitReady[2*p] && unitReady[2*p+1];

    // R10
    pair_needs_both_chk: assert property (@(posedge clk) disable iff (!rstN)
      pairReady[p] |-> (busy[2*p] && busy[2*p+1]));
  end
endmodule

// File: rtl/dep_matrix.sv
module dep_matrix
  import dep_matrix_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [ID_W-1:0]      issueUnit,
  input  logic                 issuePair,
  input  logic [NUM_UNITS-1:0] issueMask,
  input  logic                 doneValid,
  input  logic [ID_W-1:0]      doneUnit,
  input  logic                 donePair,
  output logic [NUM_UNITS-1:0] unitReady,
  output logic [NUM_PAIRS-1:0] pairReady
);
  strobe_t  strobe;
  unitVec_t busy;

  dep_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueUnit  (issueUnit),
    .issuePair  (issuePair),
    .issueMask  (issueMask),
    .doneValid  (doneValid),
    .doneUnit   (doneUnit),
    .donePair   (donePair),
    .busy       (busy),
    .strobe     (strobe)
  );

  dep_datapath u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .unitReady (unitReady),
    .pairReady (pairReady)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (unitReady == '0 && pairReady == '0));
endmodule

// File: tb/dep_matrix_tb.sv
module dep_matrix_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       issueValid, issuePair, doneValid, donePair;
  logic [2:0] issueUnit, doneUnit;
  logic [7:0] issueMask;
  logic [7:0] unitReady;
  logic [3:0] pairReady;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dep_matrix u_dut (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueUnit(issueUnit), .issuePair(issuePair),
    .issueMask(issueMask),
    .doneValid(doneValid), .doneUnit(doneUnit), .donePair(donePair),
    .unitReady(unitReady), .pairReady(pairReady)
  );

  task automatic idleInputs();
    issueValid = 0; issueUnit = 0; issuePair = 0; issueMask = 0;
    doneValid  = 0; doneUnit  = 0; donePair  = 0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus; returns at the following negedge
  task automatic step(input bit iv, input logic [2:0] iu, input bit ip, input logic [7:0] im,
                      input bit dv, input logic [2:0] du, input bit dp);
    issueValid = iv; issueUnit = iu; issuePair = ip; issueMask = im;
    doneValid  = dv; doneUnit  = du; donePair  = dp;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic issue(input logic [2:0] u, input logic [7:0] m);
    step(1, u, 0, m, 0, 0, 0);
  endtask

  task automatic done(input logic [2:0] u);
    step(0, 0, 0, 0, 1, u, 0);
  endtask

  task automatic resetDut();
    idleInputs();
    rstN = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
  endtask

  task automatic tReset();
    resetDut();
    chk("R1 unitReady", unitReady, 8'h00);
    chk("R1 pairReady", {4'h0, pairReady}, 8'h00);
  endtask

  task automatic tNoDeps();
    resetDut();
    issue(3'd2, 8'h00);
    chk("R2 ready", unitReady, 8'h04);
    chk("R2 pair idle", {4'h0, pairReady}, 8'h00);
  endtask

  task automatic tSingleDep();
    resetDut();
    issue(3'd0, 8'h00);
    issue(3'd1, 8'h01);
    chk("R3 waiting", unitReady, 8'h01);
    done(3'd0);
    chk("R3 R8 released", unitReady, 8'h02);
  endtask

  task automatic tMultiCross();
    resetDut();
    issue(3'd4, 8'h00);
    issue(3'd5, 8'h00);
    chk("R10 narrow pair ready", {4'h0, pairReady}, 8'h04);
    issue(3'd0, 8'h30);
    chk("R4 R5 wide waits narrow", unitReady, 8'h30);
    done(3'd4);
    chk("R4 one producer left", unitReady, 8'h20);
    done(3'd5);
    chk("R4 all producers done", unitReady, 8'h01);
    issue(3'd6, 8'h01);
    chk("R5 narrow waits wide", unitReady, 8'h01);
    done(3'd0);
    chk("R5 narrow released", unitReady, 8'h40);
  endtask

  task automatic tSelfAndIdle();
    resetDut();
    issue(3'd3, 8'h08);
    chk("R6 self ignored", unitReady, 8'h08);
    issue(3'd1, 8'hF0);
    chk("R7 idle producers ignored", unitReady, 8'h0A);
  endtask

  task automatic tSameCycle();
    resetDut();
    issue(3'd0, 8'h00);
    step(1, 3'd7, 0, 8'h01, 1, 3'd0, 0);
    chk("R9 completing producer dropped", unitReady, 8'h80);
  endtask

  task automatic tPair();
    resetDut();
    issue(3'd4, 8'h00);
    step(1, 3'd1, 1, 8'h13, 0, 0, 0);
    chk("R10 pair waits", unitReady, 8'h10);
    chk("R10 pair not ready", {4'h0, pairReady}, 8'h00);
    done(3'd4);
    chk("R10 halves ready", unitReady, 8'h03);
    chk("R10 pairReady", {4'h0, pairReady}, 8'h01);
    step(0, 0, 0, 0, 1, 3'd1, 1);
    chk("R11 pair retired", unitReady, 8'h00);
    chk("R11 pairReady low", {4'h0, pairReady}, 8'h00);
  endtask

  task automatic tReissue();
    resetDut();
    issue(3'd2, 8'h00);
    issue(3'd5, 8'h00);
    chk("R2 two ready", unitReady, 8'h24);
    step(1, 3'd2, 0, 8'h20, 1, 3'd2, 0);
    chk("R12 reissued waits", unitReady, 8'h20);
    done(3'd5);
    chk("R12 reissued ready", unitReady, 8'h04);
  endtask

  initial begin
    rstN = 0;
    idleInputs();
    @(negedge clk);
    tReset();
    tNoDeps();
    tSingleDep();
    tMultiCross();
    tSelfAndIdle();
    tSameCycle();
    tPair();
    tReissue();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule